// File: doc/BRIEF.md
# I2C Master FIFO Data-Request Flags

This block sits between the byte engine of an I2C master and the software that feeds and drains it. It holds a transmit byte FIFO that software fills and the engine empties, and a receive byte FIFO that the engine fills and software empties. A programmable threshold per direction and a transfer byte count decide when the block asks software for more work. It raises these requests as status bits that software clears by writing ones. An enable mask selects which status bits drive the single interrupt line.

Each direction has two kinds of request. A "ready" request says a full threshold's worth of bytes can be moved. A "drain" request says the bytes left in the transfer will never fill a threshold, so software should move the remainder. A request that software has cleared is raised again only when its condition becomes newly true or a FIFO level (or the configuration) changes. Software therefore gets no interrupt storm while it decides what to do. A software push into a full transmit FIFO and a software pop from an empty receive FIFO are dropped, and each sets its own sticky error bit.

Software reaches the block through a single-cycle write port with a 3-bit select code. It pops receive bytes on a separate strobe. The engine uses pop/push strobes with show-ahead data.

Top module: `i2c_fifo_flags`

## Requirements
- R1: After reset, status, int_en and irq are all zero, both FIFO levels are zero, eng_tx_avail is 0 and eng_rx_space is 1.
- R2: With select code 0 (configuration), reg_wdata[5:0] holds the transmit threshold minus one. Status bit 0 (transmit ready) is set when the transmit level is below the threshold and the bytes not yet pushed in the transfer are at least the threshold. The transfer length is written with select code 1, and transmit bytes are pushed with select code 5 using reg_wdata[7:0].
- R3: Status bit 1 (transmit drain) is set instead of bit 0 when the transmit level is below the threshold and between one and threshold-minus-one bytes of the transfer remain to be pushed.
- R4: The receive threshold minus one sits in reg_wdata[13:8] of a configuration write. Status bit 2 (receive ready) is set when the receive level reaches the threshold.
- R5: Status bit 3 (receive drain) is set when every byte of the transfer has been received and the receive FIFO holds at least one but fewer than the threshold bytes. Bit 2 stays clear in that case.
- R6: A write with select code 2 clears each status bit whose reg_wdata bit is 1.
- R7: irq is the OR over status ANDed with int_en. Select code 3 sets int_en bits that are written 1, and select code 4 clears them.
- R8: A configuration write with reg_wdata[6] = 1 empties the transmit FIFO, and one with reg_wdata[14] = 1 empties the receive FIFO.
- R9: A software push into a full transmit FIFO is dropped and sets sticky status bit 4. A software pop of an empty receive FIFO is dropped and sets sticky status bit 5.
- R10: A cleared ready or drain bit stays clear while its condition holds with no level change, and sets again after the next FIFO level change that keeps the condition true.
- R11: Both FIFOs deliver bytes in the order they were pushed, with the head byte shown before the pop.
- R12: depth_code reports n, where the FIFO depth is 8 << n bytes, and the transmit FIFO accepts exactly that many bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Software write strobe |
| reg_sel | input | 3 | Write select code (0 config, 1 length, 2 status clear, 3 enable set, 4 enable clear, 5 transmit byte) |
| reg_wdata | input | 16 | Software write data |
| sw_rx_pop | input | 1 | Software pop of the receive FIFO |
| rx_rdata | output | 8 | Receive FIFO head byte |
| eng_tx_pop | input | 1 | Engine pop of the transmit FIFO |
| eng_tx_data | output | 8 | Transmit FIFO head byte |
| eng_tx_avail | output | 1 | Transmit FIFO is not empty |
| eng_rx_push | input | 1 | Engine push into the receive FIFO |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| eng_rx_space | output | 1 | Receive FIFO is not full |
| status | output | 6 | Request and error bits |
| int_en | output | 6 | Interrupt enable mask |
| irq | output | 1 | Interrupt line |
| tx_level | output | LVL_W | Transmit FIFO fill level |
| rx_level | output | LVL_W | Receive FIFO fill level |
| depth_code | output | 2 | FIFO depth code n |

## Verification
The embedded properties check on every cycle that a FIFO level never exceeds the depth. They also check that a push into a full FIFO leaves the level unchanged, that a flush empties the FIFO on the next edge and that the two transmit requests never rise together. Further properties cover that a receive drain only rises once the transfer is complete, that an underflow always leaves its sticky bit set, that a cleared request with no new level change stays clear, and that a zero mask keeps irq low. Whether the right flag appears at the right level, the choice between ready and drain as the remaining count crosses the threshold, byte ordering, and the effect of flush and mask writes come out only of the bench's directed sequences.

// File: rtl/i2c_fifo_flags_pkg.sv
package i2c_fifo_flags_pkg;

    typedef enum logic [2:0] {
        SEL_CFG     = 3'd0,
        SEL_LEN     = 3'd1,
        SEL_STATCLR = 3'd2,
        SEL_IENSET  = 3'd3,
        SEL_IENCLR  = 3'd4,
        SEL_TXBYTE  = 3'd5
    } reg_sel_e;

    localparam int ST_TXRDY = 0;
    localparam int ST_TXDRN = 1;
    localparam int ST_RXRDY = 2;
    localparam int ST_RXDRN = 3;
    localparam int ST_TXOVF = 4;
    localparam int ST_RXUNF = 5;

    localparam int NUM_REQ  = 4;
    localparam int NUM_STAT = 6;

    localparam int CFG_TXFLUSH = 6;
    localparam int CFG_RXFLUSH = 14;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [LW-1:0]         lvl;
    } fifo_st_t;

    fifo_st_t q, d;
    logic     do_push, do_pop;

    assign full  = (q.lvl == LW'(DEPTH));
    assign empty = (q.lvl == '0);
    assign head  = q.mem[q.rp];
    assign level = q.lvl;

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.lvl = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = push_data;
                d.wp        = q.wp + AW'(1);
            end
            if (do_pop) begin
                d.rp = q.rp + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   d.lvl = q.lvl + LW'(1);
                2'b01:   d.lvl = q.lvl - LW'(1);
                default: d.lvl = q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.lvl <= LW'(DEPTH));

    p_full_push_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == LW'(DEPTH)));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/req_flag.sv
module req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic arm,
    input  logic clr,
    output logic flag
);

    typedef struct packed {
        logic flag;
        logic cond_prev;
    } flag_st_t;

    flag_st_t q, d;
    logic     set_evt;

    assign flag = q.flag;

    always_comb begin
        d           = q;
        set_evt     = cond && (arm || !q.cond_prev);
        d.cond_prev = cond;
        d.flag      = (q.flag && !clr) || set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    p_cleared_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.flag && !arm && q.cond_prev) |=> !q.flag);

endmodule

// File: rtl/i2c_fifo_flags.sv
module i2c_fifo_flags
    import i2c_fifo_flags_pkg::*;
#(
    parameter int FIFO_CODE = 2,
    parameter int CNT_W     = 16,
    localparam int DEPTH    = 8 << FIFO_CODE,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [15:0]      reg_wdata,
    input  logic             sw_rx_pop,
    output logic [7:0]       rx_rdata,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_data,
    output logic             eng_tx_avail,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_data,
    output logic             eng_rx_space,
    output logic [5:0]       status,
    output logic [5:0]       int_en,
    output logic             irq,
    output logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] rx_level,
    output logic [1:0]       depth_code
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [5:0]       thr_tx_m1;
        logic [5:0]       thr_rx_m1;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] tx_pushed;
        logic [CNT_W-1:0] rx_got;
        logic [1:0]       sticky;
        logic [5:0]       ien;
        logic             arm;
    } ctl_st_t;

    ctl_st_t q, d;

    logic wr_cfg, wr_len, wr_clr, wr_iset, wr_iclr, wr_tx;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_push_ok, tx_ovf, rx_pop_ok, rx_unf, eng_pop_ok, eng_push_ok;
    logic tx_flush, rx_flush;
    logic [CNT_W-1:0] thr_tx, thr_rx, tx_left, rx_left, tx_lvl_w, rx_lvl_w;
    logic [NUM_REQ-1:0] req_cond, req_clr, req_flag_v;

    // register write decode
    always_comb begin
        wr_cfg  = reg_we && (reg_sel == SEL_CFG);
        wr_len  = reg_we && (reg_sel == SEL_LEN);
        wr_clr  = reg_we && (reg_sel == SEL_STATCLR);
        wr_iset = reg_we && (reg_sel == SEL_IENSET);
        wr_iclr = reg_we && (reg_sel == SEL_IENCLR);
        wr_tx   = reg_we && (reg_sel == SEL_TXBYTE);
    end

    always_comb begin
        tx_push_ok  = wr_tx && !tx_full;
        tx_ovf      = wr_tx && tx_full;
        rx_pop_ok   = sw_rx_pop && !rx_empty;
        rx_unf      = sw_rx_pop && rx_empty;
        eng_pop_ok  = eng_tx_pop && !tx_empty;
        eng_push_ok = eng_rx_push && !rx_full;
        tx_flush    = wr_cfg && reg_wdata[CFG_TXFLUSH];
        rx_flush    = wr_cfg && reg_wdata[CFG_RXFLUSH];
    end

    byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (wr_tx),
        .push_data (reg_wdata[7:0]),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (sw_rx_pop),
        .head      (rx_rdata),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // request conditions from thresholds, levels and remaining count
    always_comb begin
        thr_tx   = CNT_W'(q.thr_tx_m1) + CNT_W'(1);
        thr_rx   = CNT_W'(q.thr_rx_m1) + CNT_W'(1);
        tx_lvl_w = CNT_W'(tx_level);
        rx_lvl_w = CNT_W'(rx_level);
        tx_left  = (q.len > q.tx_pushed) ? (q.len - q.tx_pushed) : '0;
        rx_left  = (q.len > q.rx_got) ? (q.len - q.rx_got) : '0;

        req_cond[ST_TXRDY] = (tx_lvl_w < thr_tx) && (tx_left >= thr_tx);
        req_cond[ST_TXDRN] = (tx_lvl_w < thr_tx) && (tx_left != '0)
                             && (tx_left < thr_tx);
        req_cond[ST_RXRDY] = (rx_lvl_w >= thr_rx);
        req_cond[ST_RXDRN] = (rx_left == '0) && (rx_lvl_w != '0)
                             && (rx_lvl_w < thr_rx);

        req_clr = wr_clr ? reg_wdata[NUM_REQ-1:0] : '0;
    end

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        req_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (req_cond[g]),
            .arm   (q.arm),
            .clr   (req_clr[g]),
            .flag  (req_flag_v[g])
        );
    end

    // control state next value
    always_comb begin
        d = q;
        if (wr_cfg) begin
            d.thr_tx_m1 = reg_wdata[5:0];
            d.thr_rx_m1 = reg_wdata[13:8];
        end
        if (wr_len) begin
            d.len       = reg_wdata[CNT_W-1:0];
            d.tx_pushed = '0;
            d.rx_got    = '0;
        end else begin
            if (tx_push_ok && (q.tx_pushed != CNT_MAX)) begin
                d.tx_pushed = q.tx_pushed + CNT_W'(1);
            end
            if (eng_push_ok && (q.rx_got != CNT_MAX)) begin
                d.rx_got = q.rx_got + CNT_W'(1);
            end
        end
        if (wr_clr) begin
            d.sticky = q.sticky & ~reg_wdata[ST_RXUNF:ST_TXOVF];
        end
        if (tx_ovf) d.sticky[0] = 1'b1;
        if (rx_unf) d.sticky[1] = 1'b1;
        if (wr_iset) d.ien = q.ien | reg_wdata[NUM_STAT-1:0];
        if (wr_iclr) d.ien = q.ien & ~reg_wdata[NUM_STAT-1:0];
        d.arm = tx_push_ok || eng_pop_ok || tx_flush || rx_pop_ok
                || eng_push_ok || rx_flush || wr_cfg || wr_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign status       = {q.sticky, req_flag_v};
    assign int_en       = q.ien;
    assign irq          = |(status & q.ien);
    assign eng_tx_avail = !tx_empty;
    assign eng_rx_space = !rx_full;
    assign depth_code   = 2'(FIFO_CODE);

    p_tx_req_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(status[ST_TXRDY]) && $rose(status[ST_TXDRN])));

    p_rdr_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_RXDRN]) |-> $past(rx_left == '0));

    p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rx_pop && rx_empty) |=> status[ST_RXUNF]);

    p_mask_blocks_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq);

endmodule

// File: tb/i2c_fifo_flags_bench.sv
module i2c_fifo_flags_bench;

    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_sel = '0;
    logic [15:0]      reg_wdata = '0;
    logic             sw_rx_pop = 1'b0;
    logic [7:0]       rx_rdata;
    logic             eng_tx_pop = 1'b0;
    logic [7:0]       eng_tx_data;
    logic             eng_tx_avail;
    logic             eng_rx_push = 1'b0;
    logic [7:0]       eng_rx_data = '0;
    logic             eng_rx_space;
    logic [5:0]       status;
    logic [5:0]       int_en;
    logic             irq;
    logic [LVL_W-1:0] tx_level;
    logic [LVL_W-1:0] rx_level;
    logic [1:0]       depth_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    i2c_fifo_flags u_i2c_fifo_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .sw_rx_pop    (sw_rx_pop),
        .rx_rdata     (rx_rdata),
        .eng_tx_pop   (eng_tx_pop),
        .eng_tx_data  (eng_tx_data),
        .eng_tx_avail (eng_tx_avail),
        .eng_rx_push  (eng_rx_push),
        .eng_rx_data  (eng_rx_data),
        .eng_rx_space (eng_rx_space),
        .status       (status),
        .int_en       (int_en),
        .irq          (irq),
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .depth_code   (depth_code)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic eng_pop(input logic [7:0] exp);
        @(negedge clk);
        check("R11 tx order", eng_tx_data, exp);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1'b1;
        eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic sw_pop(input logic [7:0] exp);
        @(negedge clk);
        check("R11 rx order", rx_rdata, exp);
        sw_rx_pop = 1'b1;
        @(negedge clk);
        sw_rx_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", status, 0);
        check("R1 irq", irq, 0);
        check("R1 int_en", int_en, 0);
        check("R1 levels", {tx_level, rx_level}, 0);
        check("R1 avail/space", {eng_tx_avail, eng_rx_space}, 1);
        check("R12 depth code", depth_code, 2);
    endtask

    task automatic t_tx_flags();
        wr(3'd0, 16'h0003);          // tx threshold 4
        wr(3'd1, 16'd10);            // length 10
        settle();
        check("R2 xrdy on length", status[1:0], 2'b01);
        check("R7 masked irq", irq, 0);
        wr(3'd3, 16'h0001);
        check("R7 irq enabled", irq, 1);
        wr(3'd2, 16'h003F);
        settle();
        check("R6 w1c clears", status[0], 0);
        check("R10 no rearm", status[0], 0);
        for (int i = 0; i < 6; i++) wr(3'd5, 16'(8'h10 + i));
        wr(3'd2, 16'h003F);
        settle();
        check("R2 level 6 no req", status[1:0], 2'b00);
        eng_pop(8'h10);
        eng_pop(8'h11);
        eng_pop(8'h12);
        settle();
        check("R2 xrdy below thr", status[1:0], 2'b01);
        wr(3'd2, 16'h003F);
        wr(3'd5, 16'h0016);
        settle();
        check("R2 level at thr no req", status[1:0], 2'b00);
        eng_pop(8'h13);
        settle();
        check("R3 xdr not xrdy", status[1:0], 2'b10);
        wr(3'd2, 16'h0002);
        repeat (3) settle();
        check("R10 cleared stays clear", status[1], 0);
        eng_pop(8'h14);
        settle();
        check("R10 rearm on level change", status[1:0], 2'b10);
        wr(3'd4, 16'h003F);
    endtask

    task automatic t_overflow();
        wr(3'd0, 16'h0043);          // tx flush
        check("R8 tx flush", tx_level, 0);
        wr(3'd1, 16'd200);
        for (int i = 0; i < 33; i++) wr(3'd5, 16'(8'h40 + i));
        settle();
        check("R9 overflow sticky", status[4], 1);
        check("R12 depth 32", tx_level, 32);
        check("R9 head undisturbed", eng_tx_data, 8'h40);
    endtask

    task automatic t_rx_flags();
        wr(3'd0, 16'h0203);          // rx threshold 3
        wr(3'd2, 16'h003F);
        wr(3'd1, 16'd5);
        eng_push(8'hA0);
        eng_push(8'hA1);
        eng_push(8'hA2);
        settle();
        check("R4 rrdy at thr", status[3:2], 2'b01);
        sw_pop(8'hA0);
        sw_pop(8'hA1);
        sw_pop(8'hA2);
        wr(3'd2, 16'h003F);
        eng_push(8'hA3);
        eng_push(8'hA4);
        settle();
        check("R5 rdr on last", status[3:2], 2'b10);
        check("R5 rx level", rx_level, 2);
        wr(3'd0, 16'h4203);          // rx flush
        check("R8 rx flush", rx_level, 0);
    endtask

    task automatic t_underflow_irq();
        wr(3'd2, 16'h003F);
        @(negedge clk);
        sw_rx_pop = 1'b1;
        @(negedge clk);
        sw_rx_pop = 1'b0;
        settle();
        check("R9 underflow sticky", status[5], 1);
        check("R9 rx level stays 0", rx_level, 0);
        wr(3'd3, 16'h0020);
        check("R7 irq on underflow", irq, 1);
        wr(3'd4, 16'h003F);
        check("R7 irq masked", irq, 0);
        check("R7 status kept", status[5], 1);
        wr(3'd2, 16'h0020);
        check("R6 w1c sticky", status[5], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_flags();
        t_overflow();
        t_rx_flags();
        t_underflow_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule